// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block times the strobes of a multiplexed external bus for an 8-bit controller core. It runs on the oscillator clock. Twelve clocks make one machine cycle: six states of two phases each. Every machine cycle is either a code cycle or a data cycle.

A code cycle has two address-latch pulses. It can also carry two program-store read strobes, one in each half of the cycle. A data cycle serves an external data move. It keeps only the first latch pulse, drops both program-store strobes, and drives one long read or write strobe.

The block also tells the port logic when the low data port carries an address and when it carries write data. It tells the capture registers when to latch an instruction byte or a read byte, and it picks the source of the high address byte.

The core raises its requests for the coming machine cycle. These are code fetch, table read, data read, data write and wide addressing. It also sets the mode inputs: latch-pulse disable, idle, power-down, emulation and external execution. The block samples all of these on the last clock of each machine cycle and holds them for the whole next cycle.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle is 12 clocks, tick 0 to tick 11. In a code cycle `ale_o` is high on ticks 0, 1, 6 and 7 only, so each pulse lasts 2 clocks.
- R2: A data cycle keeps the latch pulse on ticks 0 and 1, drops the one on ticks 6 and 7, and keeps `psen_n_o` high for all 12 ticks.
- R3: In a code cycle whose inputs had `fetch_i` with `ext_exec_i`, or had `movc_i`, `psen_n_o` is low on ticks 3 to 5 and 9 to 11.
- R4: In a code cycle with internal execution and no table read, `psen_n_o` stays high.
- R5: In a data cycle the strobe (`rd_n_o` for a read, `wr_n_o` for a write) is low on ticks 5 to 10. That is 6 clocks, starting 3 clocks after the latch pulse falls. When read and write are both requested, read wins. The two strobes are never low together.
- R6: The inputs are sampled at the end of tick 11 and apply to the whole next machine cycle. A data request starts a data cycle only if the current cycle is a code cycle, so data cycles never follow each other.
- R7: `hi_sel_o` selects the high address byte. 0 means the program counter and is used in every code cycle. 1 means the data pointer high byte and is used in a data cycle with `movx_wide_i`. 2 means the port-2 register and is used in a data cycle without `movx_wide_i`.
- R8: `p0_addr_o` is high on ticks 0 to 2 of each half-cycle that carries a bus access. `p0_wdata_o` is high on ticks 3 to 11 of a write cycle. `code_latch_o` pulses on ticks 5 and 11 of an active code cycle. `rd_latch_o` pulses on tick 10 of a read cycle.
- R9: With `ale_dis_i` set, internal execution, and no data request, table read, emulation, idle or power-down, `ale_o` stays low for the whole cycle.
- R10: `ale_dis_i` has no effect when any of these holds: external execution, a pending or running data cycle, a table read, emulation, or idle.
- R11: In idle, `ale_o` and `psen_n_o` are held high, and a data request does not start a data cycle. In power-down both are held low. Power-down overrides idle.
- R12: While `rst_ni` is low, the sequencer sits at tick 0 of a quiet code cycle. `ale_o` is high, `psen_n_o`, `rd_n_o` and `wr_n_o` are high, and the port and latch outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Code fetch requested for next cycle |
| movc_i | input | 1 | Table read from code memory |
| movx_rd_i | input | 1 | External data read request |
| movx_wr_i | input | 1 | External data write request |
| movx_wide_i | input | 1 | Data access uses 16-bit pointer |
| ale_dis_i | input | 1 | Latch-pulse disable control bit |
| idle_i | input | 1 | Core in idle |
| pdown_i | input | 1 | Core in power-down |
| emu_i | input | 1 | Emulation mode |
| ext_exec_i | input | 1 | Code executes from external memory |
| ale_o | output | 1 | Address latch enable |
| psen_n_o | output | 1 | Program store read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_addr_o | output | 1 | Low port drives low address byte |
| p0_wdata_o | output | 1 | Low port drives write data |
| hi_sel_o | output | 2 | High address byte source select |
| code_latch_o | output | 1 | Capture instruction byte |
| rd_latch_o | output | 1 | Capture read data byte |

## Verification
The latch-pulse disable can be set while a data move, a table read, emulation or idle is also active, and these overlaps are where the block is most likely to go wrong. The vector table holds the disable bit high across each of those cases. It judges the result by the full 12-tick ALE pattern: both pulses, one pulse, held high, or none. A read and a write requested in the same cycle are judged the same way: the read strobe pattern must appear and the write strobe must stay high.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    HI_PC  = 2'd0,
    HI_DPH = 2'd1,
    HI_P2  = 2'd2
  } hi_src_e;

  typedef enum logic {
    CYC_CODE = 1'b0,
    CYC_DATA = 1'b1
  } cyc_kind_e;

  // attributes fixed for one machine cycle
  typedef struct packed {
    cyc_kind_e kind;
    logic      is_wr;
    logic      wide;
    logic      code_act;
    logic      ale_off;
    logic      idle;
    logic      pdown;
  } cyc_cfg_t;

endpackage

// File: rtl/ebs_tick_ring.sv
module ebs_tick_ring #(
  parameter int unsigned STATES = 6,
  parameter int unsigned PHASES = 2,
  parameter int unsigned TW     = $clog2(STATES * PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] tick_o,
  output logic          last_o
);

  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [STATES-1:0] st_q;
  logic [PW-1:0]     ph_q;
  logic [TW-1:0]     st_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= STATES'(1);
      ph_q <= '0;
    end else if (ph_q == PW'(PHASES - 1)) begin
      ph_q <= '0;
      st_q <= {st_q[STATES-2:0], st_q[STATES-1]};
    end else begin
      ph_q <= ph_q + PW'(1);
    end
  end

  always_comb begin
    st_idx = '0;
    for (int i = 0; i < int'(STATES); i++) begin
      if (st_q[i]) st_idx = TW'(i);
    end
  end

  assign tick_o = st_idx * TW'(PHASES) + TW'(ph_q);
  assign last_o = st_q[STATES-1] && (ph_q == PW'(PHASES - 1));

  p_onehot_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(st_q));

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (tick_o == '0));

endmodule

// File: rtl/ebs_cycle_ctrl.sv
module ebs_cycle_ctrl
  import ebs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     last_i,
  input  logic     fetch_i,
  input  logic     movc_i,
  input  logic     rd_req_i,
  input  logic     wr_req_i,
  input  logic     wide_i,
  input  logic     ale_dis_i,
  input  logic     idle_i,
  input  logic     pdown_i,
  input  logic     emu_i,
  input  logic     ext_exec_i,
  output cyc_cfg_t cfg_o
);

  cyc_cfg_t cfg_q, cfg_d;
  logic     sleep, go_data, suspend;

  assign sleep   = idle_i | pdown_i;
  // data cycles never run back to back
  assign go_data = (cfg_q.kind == CYC_CODE) && (rd_req_i || wr_req_i) && !sleep;
  assign suspend = go_data | rd_req_i | wr_req_i | movc_i | emu_i | ext_exec_i | sleep;

  always_comb begin
    cfg_d.kind     = go_data ? CYC_DATA : CYC_CODE;
    cfg_d.is_wr    = go_data && !rd_req_i && wr_req_i;
    cfg_d.wide     = go_data && wide_i;
    cfg_d.code_act = !go_data && !sleep && ((fetch_i && ext_exec_i) || movc_i);
    cfg_d.ale_off  = ale_dis_i && !suspend;
    cfg_d.idle     = idle_i;
    cfg_d.pdown    = pdown_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{kind: CYC_CODE, default: 1'b0};
    end else if (last_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  p_no_back2back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && cfg_q.kind == CYC_DATA) |=> (cfg_q.kind == CYC_CODE));

  p_hold_mid_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(cfg_q));

  p_idle_blocks_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && sleep) |=> (cfg_q.kind == CYC_CODE));

endmodule

// File: rtl/ebs_strobe_dec.sv
module ebs_strobe_dec
  import ebs_pkg::*;
#(
  parameter int unsigned TICKS  = 12,
  parameter int unsigned TW     = $clog2(TICKS),
  parameter int unsigned ALE_W  = 2,
  parameter int unsigned PSEN_W = 3,
  parameter int unsigned STB_W  = 6,
  parameter int unsigned RD_DLY = 3
) (
  input  logic [TW-1:0] tick_i,
  input  cyc_cfg_t      cfg_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          p0_addr_o,
  output logic          p0_wdata_o,
  output hi_src_e       hi_sel_o,
  output logic          code_latch_o,
  output logic          rd_latch_o
);

  localparam int NSLOT      = 2;
  localparam int SLOT       = int'(TICKS) / NSLOT;
  localparam int ADDR_N     = int'(ALE_W) + 1;         // one tick of address hold
  localparam int PSEN_START = int'(ALE_W) + 1;
  localparam int PSEN_END   = PSEN_START + int'(PSEN_W) - 1;
  localparam int STB_START  = int'(ALE_W) + int'(RD_DLY);
  localparam int STB_END    = STB_START + int'(STB_W) - 1;
  localparam int WD_START   = int'(ALE_W) + 1;

  int t;
  assign t = int'(tick_i);

  logic data_cyc, code_bus, in_stb;
  logic [NSLOT-1:0] slot_ale, slot_psen, slot_addr, slot_clat;

  assign data_cyc = (cfg_i.kind == CYC_DATA);
  assign code_bus = !data_cyc && cfg_i.code_act;
  assign in_stb   = (t >= STB_START) && (t <= STB_END);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int B = s * SLOT;
    logic ale_en, addr_en;
    if (s == 0) begin : g_first
      assign ale_en  = 1'b1;
      assign addr_en = code_bus | data_cyc;
    end else begin : g_rest
      assign ale_en  = !data_cyc;
      assign addr_en = code_bus;
    end
    assign slot_ale[s]  = ale_en && (t >= B) && (t < B + int'(ALE_W));
    assign slot_addr[s] = addr_en && (t >= B) && (t < B + ADDR_N);
    assign slot_psen[s] = code_bus && (t >= B + PSEN_START) && (t <= B + PSEN_END);
    assign slot_clat[s] = code_bus && (t == B + PSEN_END);
  end

  always_comb begin
    ale_o        = 1'b0;
    psen_n_o     = 1'b1;
    rd_n_o       = 1'b1;
    wr_n_o       = 1'b1;
    p0_addr_o    = 1'b0;
    p0_wdata_o   = 1'b0;
    code_latch_o = 1'b0;
    rd_latch_o   = 1'b0;
    hi_sel_o     = HI_PC;
    if (cfg_i.pdown) begin
      psen_n_o = 1'b0;
    end else if (cfg_i.idle) begin
      ale_o = 1'b1;
    end else begin
      ale_o        = (|slot_ale) && !cfg_i.ale_off;
      psen_n_o     = !(|slot_psen);
      p0_addr_o    = |slot_addr;
      code_latch_o = |slot_clat;
      if (data_cyc) begin
        rd_n_o     = !(!cfg_i.is_wr && in_stb);
        wr_n_o     = !(cfg_i.is_wr && in_stb);
        p0_wdata_o = cfg_i.is_wr && (t >= WD_START);
        rd_latch_o = !cfg_i.is_wr && (t == STB_END);
        hi_sel_o   = cfg_i.wide ? HI_DPH : HI_P2;
      end
    end
  end

  always_comb begin
    a_strobe_excl_r5: assert (rd_n_o || wr_n_o);
    a_bus_excl_r8: assert (!(p0_addr_o && p0_wdata_o));
  end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int unsigned STATES = 6,
  parameter int unsigned PHASES = 2,
  parameter int unsigned ALE_W  = 2,
  parameter int unsigned PSEN_W = 3,
  parameter int unsigned STB_W  = 6,
  parameter int unsigned RD_DLY = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fetch_i,
  input  logic       movc_i,
  input  logic       movx_rd_i,
  input  logic       movx_wr_i,
  input  logic       movx_wide_i,
  input  logic       ale_dis_i,
  input  logic       idle_i,
  input  logic       pdown_i,
  input  logic       emu_i,
  input  logic       ext_exec_i,
  output logic       ale_o,
  output logic       psen_n_o,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       p0_addr_o,
  output logic       p0_wdata_o,
  output logic [1:0] hi_sel_o,
  output logic       code_latch_o,
  output logic       rd_latch_o
);

  localparam int unsigned TICKS     = STATES * PHASES;
  localparam int unsigned TW        = $clog2(TICKS);
  localparam int unsigned STB_START = ALE_W + RD_DLY;

  logic [TW-1:0] tick;
  logic          last;
  cyc_cfg_t      cfg;
  hi_src_e       hi_sel;

  ebs_tick_ring #(
    .STATES(STATES),
    .PHASES(PHASES),
    .TW    (TW)
  ) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick),
    .last_o(last)
  );

  ebs_cycle_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .fetch_i   (fetch_i),
    .movc_i    (movc_i),
    .rd_req_i  (movx_rd_i),
    .wr_req_i  (movx_wr_i),
    .wide_i    (movx_wide_i),
    .ale_dis_i (ale_dis_i),
    .idle_i    (idle_i),
    .pdown_i   (pdown_i),
    .emu_i     (emu_i),
    .ext_exec_i(ext_exec_i),
    .cfg_o     (cfg)
  );

  ebs_strobe_dec #(
    .TICKS (TICKS),
    .TW    (TW),
    .ALE_W (ALE_W),
    .PSEN_W(PSEN_W),
    .STB_W (STB_W),
    .RD_DLY(RD_DLY)
  ) u_dec (
    .tick_i      (tick),
    .cfg_i       (cfg),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .p0_addr_o   (p0_addr_o),
    .p0_wdata_o  (p0_wdata_o),
    .hi_sel_o    (hi_sel),
    .code_latch_o(code_latch_o),
    .rd_latch_o  (rd_latch_o)
  );

  assign hi_sel_o = hi_sel;

  p_rd_fall_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |-> (tick == TW'(STB_START)));

  p_wr_fall_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_o) |-> (tick == TW'(STB_START)));

  p_data_no_psen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.kind == CYC_DATA) |-> psen_n_o);

  p_ale_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> $past(ale_o, 2));

  p_idle_levels_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.idle && !cfg.pdown) |-> (ale_o && psen_n_o));

  p_pdown_levels_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.pdown |-> (!ale_o && !psen_n_o));

endmodule

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;

  // in = {fetch, movc, rd, wr, wide, ale_dis, idle, pdown, emu, ext}
  typedef struct packed {
    logic [9:0]  in;
    logic [11:0] ale, psen, rd, wr, p0a, wd, cl, rl;
    logic [1:0]  hi;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{10'b1000000001, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h1C7, 12'h000, 12'h820, 12'h000, 2'd0}, // R1 R3
    '{10'b1010100001, 12'h003, 12'hFFF, 12'h81F, 12'hFFF, 12'h007, 12'h000, 12'h000, 12'h400, 2'd1}, // R2 R5 R7
    '{10'b1000000001, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h1C7, 12'h000, 12'h820, 12'h000, 2'd0}, // R6
    '{10'b1001000000, 12'h003, 12'hFFF, 12'hFFF, 12'h81F, 12'h007, 12'hFF8, 12'h000, 12'h000, 2'd2}, // R5 R7 R8
    '{10'b1001000000, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R6 R4
    '{10'b1000010000, 12'h000, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R9
    '{10'b1000010001, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h1C7, 12'h000, 12'h820, 12'h000, 2'd0}, // R10 ext
    '{10'b1100010000, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h1C7, 12'h000, 12'h820, 12'h000, 2'd0}, // R10 R3 table read
    '{10'b1000010010, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R10 emu
    '{10'b1011010000, 12'h003, 12'hFFF, 12'h81F, 12'hFFF, 12'h007, 12'h000, 12'h000, 12'h400, 2'd2}, // R5 priority R10
    '{10'b1000000001, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h1C7, 12'h000, 12'h820, 12'h000, 2'd0}, // R6
    '{10'b1010001001, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R11 idle
    '{10'b1000000101, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R11 pdown
    '{10'b1000011000, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 2'd0}, // R10 R11
    '{10'b1010110000, 12'h003, 12'hFFF, 12'h81F, 12'hFFF, 12'h007, 12'h000, 12'h000, 12'h400, 2'd1}  // R2 R10
  };

  logic clk = 1'b0;
  logic rst_n;
  logic fetch, movc, xrd, xwr, xwide, adis, idle, pdown, emu, ext;
  logic ale, psen_n, rd_n, wr_n, p0a, wd, cl, rl;
  logic [1:0] hi;
  int n_chk = 0;
  int n_err = 0;
  int tb_tick;
  logic [11:0] g_ale, g_psen, g_rd, g_wr, g_p0a, g_wd, g_cl, g_rl;
  logic [1:0]  g_hi;

  always #2.5 clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_i(fetch), .movc_i(movc), .movx_rd_i(xrd), .movx_wr_i(xwr),
    .movx_wide_i(xwide), .ale_dis_i(adis), .idle_i(idle), .pdown_i(pdown),
    .emu_i(emu), .ext_exec_i(ext),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .p0_addr_o(p0a), .p0_wdata_o(wd), .hi_sel_o(hi),
    .code_latch_o(cl), .rd_latch_o(rl)
  );

  // bench model of the 12-tick machine cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_tick <= 0;
    else        tb_tick <= (tb_tick == 11) ? 0 : tb_tick + 1;
  end

  task automatic chk(input string tag, input int row, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s row %0d got %h exp %h", tag, row, got, exp);
    end
  endtask

  task automatic set_in(input logic [9:0] v);
    {fetch, movc, xrd, xwr, xwide, adis, idle, pdown, emu, ext} = v;
  endtask

  task automatic go_tick11();
    while (tb_tick != 11) @(negedge clk);
  endtask

  task automatic collect();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      g_ale[i] = ale; g_psen[i] = psen_n; g_rd[i] = rd_n; g_wr[i] = wr_n;
      g_p0a[i] = p0a; g_wd[i] = wd; g_cl[i] = cl; g_rl[i] = rl;
      if (i == 6) g_hi = hi;
    end
  endtask

  initial begin
    #(5ns * 20000);
    n_err++;
    $display("FAIL R1 watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_in('0);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ale",    -1, {11'd0, ale},    12'd1);
    chk("R12 psen_n", -1, {11'd0, psen_n}, 12'd1);
    chk("R12 rd_n",   -1, {11'd0, rd_n},   12'd1);
    chk("R12 wr_n",   -1, {11'd0, wr_n},   12'd1);
    chk("R12 port",   -1, {8'd0, p0a, wd, cl, rl}, 12'd0);
    chk("R12 hi_sel", -1, {10'd0, hi},     12'd0);
    rst_n = 1'b1;
    go_tick11();

    for (int r = 0; r < NV; r++) begin
      set_in(VECS[r].in);
      collect();
      chk("R1 ale pattern",     r, g_ale,  VECS[r].ale);
      chk("R3 psen_n pattern",  r, g_psen, VECS[r].psen);
      chk("R5 rd_n pattern",    r, g_rd,   VECS[r].rd);
      chk("R5 wr_n pattern",    r, g_wr,   VECS[r].wr);
      chk("R8 p0 address",      r, g_p0a,  VECS[r].p0a);
      chk("R8 p0 write data",   r, g_wd,   VECS[r].wd);
      chk("R8 code latch",      r, g_cl,   VECS[r].cl);
      chk("R8 read latch",      r, g_rl,   VECS[r].rl);
      chk("R7 hi_sel",          r, {10'd0, g_hi}, {10'd0, VECS[r].hi});
    end

    // R12: asynchronous reset in the middle of a read strobe
    set_in('0);
    collect();
    set_in(10'b1010000000);
    repeat (6) @(negedge clk);
    chk("R5 rd_n low at tick 5", 99, {11'd0, rd_n}, 12'd0);
    rst_n = 1'b0;
    #1;
    chk("R12 rd_n after reset", 99, {11'd0, rd_n}, 12'd1);
    chk("R12 ale after reset",  99, {11'd0, ale},  12'd1);
    set_in('0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule